// File: doc/BRIEF.md
# SPI Master Interrupt and FIFO Status Bank

This block is the interrupt and status register bank that sits beside the shift engine of an SPI master. It merges two kinds of condition into one seven-bit status word. The first kind is live FIFO-level flags, which are computed every cycle from the TX and RX fill levels against two thresholds that software programs. The second kind is sticky error flags, which are latched from single-cycle event pulses and kept until software clears them.

Software enables interrupt sources by writing ones to a set-strobe register. It disables them by writing ones to a clear-strobe register. It reads the resulting enables back from a separate read-only mask register. A single level interrupt line reports whether any enabled source is active. That line is registered, so it follows the status by one cycle. The FIFOs and the shifter are outside this block: they provide the fill levels and the event pulses.

The register port is a simple one. A write is a one-cycle `reg_wr` strobe with an address and data. Read data is a combinational function of `reg_addr`.

Top module: `spi_irq_bank`

## Requirements
- R1: After a synchronous reset the sticky bits and the mask register are zero, `irq` is low, and both threshold registers hold 1. Offset 0x10 therefore reads 0, and offsets 0x28 and 0x2C read 1.
- R2: Status (offset 0x04) places the sticky flags at bit 0 (RX overflow), bit 1 (mode fault) and bit 6 (TX underflow). A one-cycle pulse on the matching event input sets the flag, and the flag stays set until it is cleared.
- R3: A write to 0x04 clears each sticky bit whose data bit is 1 and leaves bits written as 0 unchanged. Writing all ones clears all three sticky bits.
- R4: An event pulse in the same cycle as a write-1-to-clear of its bit leaves the bit set.
- R5: Status bit 2 (TX not full) is 1 while the TX level is below the TX threshold. Status bit 3 (TX full) is 1 while the TX level equals TX_DEPTH.
- R6: Status bit 4 (RX not empty) is 1 while the RX level is at or above the RX threshold. Status bit 5 (RX full) is 1 while the RX level equals RX_DEPTH.
- R7: Bits 2 to 5 of the status are live and are not changed by writes to 0x04.
- R8: Writing to 0x08 sets each mask bit whose data bit is 1. Writing to 0x0C clears each mask bit whose data bit is 1. Data bits of 0 have no effect. The mask reads at 0x10 with bit positions matching the status. Offsets 0x08 and 0x0C read as 0.
- R9: `irq` equals the OR of (status AND mask) from the previous cycle.
- R10: Offsets 0x28 (TX threshold) and 0x2C (RX threshold) are read/write and store the low bits of the written data (8 bits at the default depths).
- R11: Writes to the mask register offset 0x10 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | One-cycle write strobe |
| reg_addr | input | ADDR_W | Byte offset for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| tx_level | input | $clog2(TX_DEPTH+1) | TX FIFO occupancy |
| rx_level | input | $clog2(RX_DEPTH+1) | RX FIFO occupancy |
| evt_rx_ovf | input | 1 | RX overflow event pulse |
| evt_mode_fault | input | 1 | Mode fault event pulse |
| evt_tx_unf | input | 1 | TX underflow event pulse |
| irq | output | 1 | Level interrupt |

## Verification
Each result is due at a fixed cycle:
- Level flags follow `tx_level` and `rx_level` within the same cycle. They show on `reg_rdata` as soon as the inputs settle.
- A sticky bit, a mask change or a threshold write takes effect at the clock edge that samples the pulse or the write, and is visible on the read port after that edge.
- `irq` follows one edge later than the status and mask it is built from.

The bench drives inputs shortly after the falling edge. It advances a behavioural model on each rising edge and compares `irq` and the read data of the currently addressed register at every falling edge. Each comparison therefore sees exactly the edges the design has seen.

// File: rtl/spi_irq_pkg.sv
// Package: shared offsets and status bit positions for the SPI interrupt bank.
// Assumes byte offsets fit in 8 bits; users cast to their own address width.
package spi_irq_pkg;
    localparam int N_SRC = 7;

    localparam logic [7:0] OFS_STATUS  = 8'h04;
    localparam logic [7:0] OFS_SET     = 8'h08;
    localparam logic [7:0] OFS_CLR     = 8'h0C;
    localparam logic [7:0] OFS_MASK    = 8'h10;
    localparam logic [7:0] OFS_TX_THR  = 8'h28;
    localparam logic [7:0] OFS_RX_THR  = 8'h2C;

    localparam int B_RX_OVF   = 0;
    localparam int B_MODE_FLT = 1;
    localparam int B_TX_NF    = 2;
    localparam int B_TX_FULL  = 3;
    localparam int B_RX_NE    = 4;
    localparam int B_RX_FULL  = 5;
    localparam int B_TX_UNF   = 6;
endpackage

// File: rtl/spi_irq_sticky.sv
// Module: bank of sticky event flags with write-1-to-clear.
// Assumes evt pulses are one cycle wide; a set in the same cycle as a clear wins.
module spi_irq_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    // One independent flag per event source.
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Purpose: latch the event, drop on clear unless the event repeats.
        always_ff @(posedge clk) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (evt[i]) q[i] <= 1'b1;
            else if (clr[i]) q[i] <= 1'b0;
        end
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q & $past(q & ~clr)) == $past(q & ~clr)));          // R2
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((q & $past(evt)) == $past(evt)));                 // R4
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~evt)) |=> ((q & $past(clr & ~evt)) == '0));         // R3
endmodule

// File: rtl/spi_irq_levels.sv
// Module: threshold registers and live FIFO-level flags.
// Assumes levels never exceed the FIFO depths; thresholds keep the low bits written.
module spi_irq_levels #(
    parameter int TX_DEPTH   = 128,
    parameter int RX_DEPTH   = 128,
    parameter int TX_THR_RST = 1,
    parameter int RX_THR_RST = 1,
    localparam int TX_LW = $clog2(TX_DEPTH + 1),
    localparam int RX_LW = $clog2(RX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_thr_we,
    input  logic             rx_thr_we,
    input  logic [TX_LW-1:0] tx_thr_wd,
    input  logic [RX_LW-1:0] rx_thr_wd,
    input  logic [TX_LW-1:0] tx_level,
    input  logic [RX_LW-1:0] rx_level,
    output logic [TX_LW-1:0] tx_thr,
    output logic [RX_LW-1:0] rx_thr,
    output logic             tx_nf,
    output logic             tx_full,
    output logic             rx_ne,
    output logic             rx_full
);
    // Purpose: hold the programmable thresholds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr <= TX_LW'(TX_THR_RST);
            rx_thr <= RX_LW'(RX_THR_RST);
        end else begin
            if (tx_thr_we) tx_thr <= tx_thr_wd;
            if (rx_thr_we) rx_thr <= rx_thr_wd;
        end
    end

    // Purpose: compare live levels against thresholds and depths.
    always_comb begin
        tx_nf   = tx_level < tx_thr;
        tx_full = tx_level == TX_LW'(TX_DEPTH);
        rx_ne   = rx_level >= rx_thr;
        rx_full = rx_level == RX_LW'(RX_DEPTH);
    end

    AST_THR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_thr_we |=> $stable(tx_thr));                              // R10
endmodule

// File: rtl/spi_irq_mask.sv
// Module: interrupt enable mask changed only through set and clear strobes.
// Assumes set_stb and clr_stb are never active in the same cycle.
module spi_irq_mask #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [N-1:0] bits,
    output logic [N-1:0] mask
);
    // Purpose: OR in set bits, AND out cleared bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (set_stb) mask <= mask | bits;
        else if (clr_stb) mask <= mask & ~bits;
    end

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((mask & $past(bits)) == $past(bits)));           // R8
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((mask & $past(bits)) == '0));                    // R8
    AST_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_stb || clr_stb) |=> $stable(mask));                     // R11
endmodule

// File: rtl/spi_irq_bank.sv
// Module: SPI master interrupt/status bank top. Decodes register accesses,
// assembles the status word, drives the registered interrupt line.
// Assumes one access per cycle and combinational reads.
module spi_irq_bank #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int TX_DEPTH   = 128,
    parameter int RX_DEPTH   = 128,
    parameter int TX_THR_RST = 1,
    parameter int RX_THR_RST = 1,
    localparam int TX_LW = $clog2(TX_DEPTH + 1),
    localparam int RX_LW = $clog2(RX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [TX_LW-1:0]  tx_level,
    input  logic [RX_LW-1:0]  rx_level,
    input  logic              evt_rx_ovf,
    input  logic              evt_mode_fault,
    input  logic              evt_tx_unf,
    output logic              irq
);
    import spi_irq_pkg::*;

    localparam int N_STK = 3;

    logic wr_stat, wr_set, wr_clr, wr_txt, wr_rxt;
    logic [N_STK-1:0] stk_evt, stk_clr, stk_q;
    logic [TX_LW-1:0] tx_thr;
    logic [RX_LW-1:0] rx_thr;
    logic tx_nf, tx_full, rx_ne, rx_full;
    logic [N_SRC-1:0] status, mask;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata;

    // Purpose: decode write strobes per register offset.
    always_comb begin
        wr_stat = reg_wr && (reg_addr == ADDR_W'(OFS_STATUS));
        wr_set  = reg_wr && (reg_addr == ADDR_W'(OFS_SET));
        wr_clr  = reg_wr && (reg_addr == ADDR_W'(OFS_CLR));
        wr_txt  = reg_wr && (reg_addr == ADDR_W'(OFS_TX_THR));
        wr_rxt  = reg_wr && (reg_addr == ADDR_W'(OFS_RX_THR));
    end

    // Purpose: map sticky sources to their status positions.
    always_comb begin
        stk_evt = {evt_tx_unf, evt_mode_fault, evt_rx_ovf};
        stk_clr = {N_STK{wr_stat}} &
                  {reg_wdata[B_TX_UNF], reg_wdata[B_MODE_FLT], reg_wdata[B_RX_OVF]};
    end

    spi_irq_sticky #(.N(N_STK)) u_sticky (
        .clk (clk), .rst_n (rst_n), .evt (stk_evt), .clr (stk_clr), .q (stk_q)
    );

    spi_irq_levels #(
        .TX_DEPTH (TX_DEPTH), .RX_DEPTH (RX_DEPTH),
        .TX_THR_RST (TX_THR_RST), .RX_THR_RST (RX_THR_RST)
    ) u_levels (
        .clk (clk), .rst_n (rst_n),
        .tx_thr_we (wr_txt), .rx_thr_we (wr_rxt),
        .tx_thr_wd (reg_wdata[TX_LW-1:0]), .rx_thr_wd (reg_wdata[RX_LW-1:0]),
        .tx_level (tx_level), .rx_level (rx_level),
        .tx_thr (tx_thr), .rx_thr (rx_thr),
        .tx_nf (tx_nf), .tx_full (tx_full), .rx_ne (rx_ne), .rx_full (rx_full)
    );

    spi_irq_mask #(.N(N_SRC)) u_mask (
        .clk (clk), .rst_n (rst_n), .set_stb (wr_set), .clr_stb (wr_clr),
        .bits (reg_wdata[N_SRC-1:0]), .mask (mask)
    );

    // Purpose: assemble the status word from sticky and live flags.
    always_comb begin
        status              = '0;
        status[B_RX_OVF]    = stk_q[0];
        status[B_MODE_FLT]  = stk_q[1];
        status[B_TX_NF]     = tx_nf;
        status[B_TX_FULL]   = tx_full;
        status[B_RX_NE]     = rx_ne;
        status[B_RX_FULL]   = rx_full;
        status[B_TX_UNF]    = stk_q[2];
    end

    // Purpose: register the interrupt line from enabled active sources.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(status & mask);
    end

    // Purpose: select read data by offset.
    always_comb begin
        reg_rdata = '0;
        if      (reg_addr == ADDR_W'(OFS_STATUS)) reg_rdata = DATA_W'(status);
        else if (reg_addr == ADDR_W'(OFS_MASK))   reg_rdata = DATA_W'(mask);
        else if (reg_addr == ADDR_W'(OFS_TX_THR)) reg_rdata = DATA_W'(tx_thr);
        else if (reg_addr == ADDR_W'(OFS_RX_THR)) reg_rdata = DATA_W'(rx_thr);
    end

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(status & mask))));                   // R9
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_stat, wr_set, wr_clr, wr_txt, wr_rxt}));         // R8
endmodule

// File: tb/spi_irq_bank_tb.sv
module spi_irq_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h04;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  tx_level = '0;
    logic [7:0]  rx_level = '0;
    logic        evt_rx_ovf = 1'b0, evt_mode_fault = 1'b0, evt_tx_unf = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;
    string cur_req = "R1";

    // Reference model state
    bit [2:0] m_stk;
    bit [6:0] m_mask;
    int       m_txt, m_rxt;
    bit       m_irq;

    spi_irq_bank u_dut (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .tx_level (tx_level), .rx_level (rx_level),
        .evt_rx_ovf (evt_rx_ovf), .evt_mode_fault (evt_mode_fault),
        .evt_tx_unf (evt_tx_unf), .irq (irq)
    );

    always #4 clk = ~clk;

    function automatic bit [6:0] m_status();
        bit [6:0] s;
        s[0] = m_stk[0];
        s[1] = m_stk[1];
        s[2] = int'(tx_level) < m_txt;
        s[3] = int'(tx_level) == 128;
        s[4] = int'(rx_level) >= m_rxt;
        s[5] = int'(rx_level) == 128;
        s[6] = m_stk[2];
        return s;
    endfunction

    function automatic bit [31:0] m_read();
        case (reg_addr)
            8'h04:   return 32'(m_status());
            8'h10:   return 32'(m_mask);
            8'h28:   return 32'(m_txt);
            8'h2C:   return 32'(m_rxt);
            default: return 32'h0;
        endcase
    endfunction

    // Model advance at each rising edge
    always @(posedge clk) begin
        bit [6:0] st;
        st = m_status();
        if (!rst_n) begin
            m_stk = '0; m_mask = '0; m_txt = 1; m_rxt = 1; m_irq = 1'b0;
        end else begin
            m_irq = |(st & m_mask);
            if (reg_wr && reg_addr == 8'h04) begin
                if (reg_wdata[0]) m_stk[0] = 1'b0;
                if (reg_wdata[1]) m_stk[1] = 1'b0;
                if (reg_wdata[6]) m_stk[2] = 1'b0;
            end
            if (evt_rx_ovf)     m_stk[0] = 1'b1;
            if (evt_mode_fault) m_stk[1] = 1'b1;
            if (evt_tx_unf)     m_stk[2] = 1'b1;
            if (reg_wr && reg_addr == 8'h08) m_mask = m_mask | reg_wdata[6:0];
            if (reg_wr && reg_addr == 8'h0C) m_mask = m_mask & ~reg_wdata[6:0];
            if (reg_wr && reg_addr == 8'h28) m_txt = int'(reg_wdata[7:0]);
            if (reg_wr && reg_addr == 8'h2C) m_rxt = int'(reg_wdata[7:0]);
        end
        cycles++;
    end

    // Compare at every falling edge
    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            if (irq !== m_irq) begin
                errors++;
                $display("FAIL R9 irq actual=%0b expected=%0b t=%0t", irq, m_irq, $time);
            end
            checks++;
            if (reg_rdata !== m_read()) begin
                errors++;
                $display("FAIL %s rdata@%h actual=%h expected=%h t=%0t",
                         cur_req, reg_addr, reg_rdata, m_read(), $time);
            end
        end
    end

    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        settle();
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        settle();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a);
        settle();
        reg_addr = a;
        settle();
    endtask

    task automatic pulse(input bit r, input bit m, input bit u);
        settle();
        evt_rx_ovf = r; evt_mode_fault = m; evt_tx_unf = u;
        settle();
        evt_rx_ovf = 1'b0; evt_mode_fault = 1'b0; evt_tx_unf = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        settle();
        rst_n = 1'b1;
        cmp_on = 1'b1;
        // R1: reset state of every register
        cur_req = "R1";
        rd(8'h04); rd(8'h10); rd(8'h28); rd(8'h2C); rd(8'h08);

        // R10: thresholds read/write, low bits kept
        cur_req = "R10";
        wr(8'h28, 32'h1FF); rd(8'h28);
        wr(8'h28, 32); wr(8'h2C, 1); rd(8'h28); rd(8'h2C);

        // R5: TX level flags
        cur_req = "R5";
        reg_addr = 8'h04;
        for (int v = 0; v < 6; v++) begin
            settle();
            case (v)
                0: tx_level = 0;   1: tx_level = 31; 2: tx_level = 32;
                3: tx_level = 127; 4: tx_level = 128; default: tx_level = 5;
            endcase
            settle();
        end

        // R6: RX level flags with two thresholds
        cur_req = "R6";
        for (int v = 0; v < 4; v++) begin
            settle();
            rx_level = (v == 0) ? 0 : (v == 1) ? 1 : (v == 2) ? 3 : 128;
            settle();
        end
        wr(8'h2C, 4);
        rd(8'h04);
        settle(); rx_level = 4; settle();
        settle(); rx_level = 3; rd(8'h04);
        wr(8'h2C, 1);

        // R2: sticky events set and hold
        cur_req = "R2";
        pulse(1, 0, 0); rd(8'h04);
        pulse(0, 1, 0); pulse(0, 0, 1);
        repeat (3) settle();

        // R3: write-1-to-clear
        cur_req = "R3";
        wr(8'h04, 32'h01); rd(8'h04);
        wr(8'h04, 32'h00); rd(8'h04);
        wr(8'h04, 32'h40); rd(8'h04);
        pulse(1, 0, 1);
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04);

        // R4: event coincident with clear
        cur_req = "R4";
        settle();
        reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h43; evt_rx_ovf = 1'b1; evt_tx_unf = 1'b1;
        settle();
        reg_wr = 1'b0; reg_wdata = '0; evt_rx_ovf = 1'b0; evt_tx_unf = 1'b0;
        rd(8'h04);

        // R7: live bits ignore writes
        cur_req = "R7";
        settle(); tx_level = 128; rx_level = 128; settle();
        wr(8'h04, 32'h7F); rd(8'h04);
        settle(); tx_level = 2; rx_level = 0; settle();

        // R8: set/clear strobes and mask readback
        cur_req = "R8";
        wr(8'h08, 32'h11); rd(8'h10);
        wr(8'h08, 32'h00); rd(8'h10);
        wr(8'h0C, 32'h01); rd(8'h10);
        rd(8'h0C); rd(8'h08);

        // R9: interrupt from enabled sources
        cur_req = "R9";
        settle(); rx_level = 3; settle();
        settle(); rx_level = 0; settle();
        wr(8'h08, 32'h02); pulse(0, 1, 0); rd(8'h04);
        wr(8'h04, 32'h02); rd(8'h04);
        wr(8'h0C, 32'h7F); pulse(1, 1, 1); rd(8'h04);

        // R11: writes to mask offset ignored
        cur_req = "R11";
        wr(8'h10, 32'h7F); rd(8'h10);
        wr(8'h08, 32'h40); wr(8'h10, 32'h00); rd(8'h10);
        repeat (3) settle();

        cmp_on = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #40000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule